// File: doc/BRIEF.md
# Bank-Relative Register Address Unit

This block maps the short register operands of a small processor onto physical byte addresses in on-chip RAM. General-purpose registers are not a flip-flop file. They are a window of sixteen words in RAM, and a writable bank-base register selects where that window starts. Each access brings an operand kind and a short code, and the block adds a scaled offset to the bank base:

- A word-register number is scaled by two.
- A byte-register number is not scaled.
- A two-bit pointer number reaches only the first four words.
- An eight-bit register code falls into the window only when its upper nibble is all ones.

The block contains a word-wide RAM model with byte lanes. GPR reads and writes can therefore be carried out and checked end to end.

Requests arrive on a valid/ready channel. The unit never applies back-pressure: `req_ready` stays high, and a request is accepted on every rising edge where `req_valid` is high. Read responses come back on `rsp_valid`/`rsp_data` exactly one cycle after acceptance. There is no ready signal on the response side, so the consumer must take the response in that cycle. Writes and out-of-window requests produce no response. The bank-base port pair is a plain control interface.

Top module: `cpgpr_unit`

## Requirements
- R1: Reset clears the bank base to 0. A write through `cp_we` stores `cp_wdata` with bit 0 forced to 0, and the new value is visible on `cp_q` after the next rising edge.
- R2: Kind 0 (word register) gives `phys_addr = cp_q + 2*req_code[3:0]` with `is_byte` low. Bits 7:4 of the code are ignored.
- R3: Kind 1 (byte register) gives `phys_addr = cp_q + req_code[3:0]` with `is_byte` high.
- R4: Kind 2 (indirect pointer) gives `phys_addr = cp_q + 2*req_code[1:0]` with `is_byte` low, whatever the other code bits are.
- R5: Kind 3 (eight-bit register code) with `req_code[7:4] == 4'hF` gives `phys_addr = cp_q + 2*req_code[3:0]`, with `is_byte` low and `out_of_window` low.
- R6: Kind 3 with `req_code[7:4] != 4'hF` raises `out_of_window`. Such a request writes no RAM and produces no response.
- R7: An accepted in-window read raises `rsp_valid` for one cycle, one clock after acceptance, with the RAM contents. An accepted write takes effect at its acceptance edge.
- R8: Byte lanes are little-endian: an even address selects bits 7:0 and an odd address selects bits 15:8. A byte write changes only its own lane. A byte read returns the lane zero-extended in `rsp_data[7:0]`.
- R9: Address formation is combinational from the current `cp_q`. A request in the same cycle as a bank-base write uses the old base, and the request in the next cycle uses the new base.
- R10: Address arithmetic wraps modulo 2^ADDR_W without any flag. The RAM uses address bits RAM_AW:0, so addresses alias modulo its size.
- R11: `req_ready` is high in every cycle, including during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_we | input | 1 | Bank-base write strobe |
| cp_wdata | input | ADDR_W | New bank base |
| cp_q | output | ADDR_W | Current bank base (always even) |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready (constant high) |
| req_kind | input | 2 | 0 word reg, 1 byte reg, 2 pointer, 3 eight-bit code |
| req_code | input | 8 | Short register code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| phys_addr | output | ADDR_W | Physical byte address |
| is_byte | output | 1 | Access is byte-wide |
| out_of_window | output | 1 | Eight-bit code lies outside the GPR window |
| rsp_valid | output | 1 | Read response valid |
| rsp_data | output | 16 | Read response data |

## Verification
The bench builds the unit with ADDR_W = 16 and RAM_AW = 5, so the RAM holds 64 bytes and the whole bank, its byte lanes and its aliasing all fit in a byte-array model. With 16-bit addresses, a bank base of FFFEh reaches the top of the address space and makes the modulo wrap observable. For several bank bases, the bench sweeps all four operand kinds across all 256 codes and compares each address arithmetically. It then fills a bank, overwrites single bytes, issues out-of-window writes and moves the base, and checks every read against the model.

// File: rtl/cpgpr_pkg.sv
package cpgpr_pkg;
  typedef enum logic [1:0] {
    OP_WREG = 2'd0,
    OP_BREG = 2'd1,
    OP_PTR  = 2'd2,
    OP_SREG = 2'd3
  } opnd_kind_e;

  localparam int unsigned DATA_W  = 16;
  localparam int unsigned CODE_W  = 8;
  localparam logic [3:0]  WIN_TAG = 4'hF;
endpackage

// File: rtl/cpgpr_ctx_reg.sv
module cpgpr_ctx_reg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  // bank base is word aligned: bit 0 never stored
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= {wdata[W-1:1], 1'b0};
  end
endmodule

// File: rtl/cpgpr_addr_calc.sv
module cpgpr_addr_calc
  import cpgpr_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]      base,
  input  opnd_kind_e        kind,
  input  logic [CODE_W-1:0] code,
  output logic [W-1:0]      addr,
  output logic              byte_acc,
  output logic              oow
);
  logic [W-1:0] offset;

  always_comb begin
    offset   = '0;
    byte_acc = 1'b0;
    oow      = 1'b0;
    unique case (kind)
      OP_WREG: offset = W'({code[3:0], 1'b0});
      OP_BREG: begin
        offset   = W'(code[3:0]);
        byte_acc = 1'b1;
      end
      OP_PTR:  offset = W'({code[1:0], 1'b0});
      OP_SREG: begin
        if (code[7:4] == WIN_TAG) offset = W'({code[3:0], 1'b0});
        else                      oow    = 1'b1;
      end
      default: offset = '0;
    endcase
  end

  // modulo-2^W sum, carry discarded
  assign addr = base + offset;
endmodule

// File: rtl/cpgpr_ram.sv
module cpgpr_ram
  import cpgpr_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              we,
  input  logic              byte_acc,
  input  logic [AW-1:0]     waddr,
  input  logic              lane,
  input  logic [DATA_W-1:0] wdata,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned LANES = DATA_W / 8;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LANES-1:0]  lane_we;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lane_we[i] = en && we && (!byte_acc || (lane == i[0]));
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[waddr][g*8 +: 8] <= (byte_acc ? wdata[7:0] : wdata[g*8 +: 8]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      rvalid <= en && !we;
      if (en && !we) begin
        if (byte_acc) rdata <= {8'h00, (lane ? mem[waddr][15:8] : mem[waddr][7:0])};
        else          rdata <= mem[waddr];
      end
    end
  end
endmodule

// File: rtl/cpgpr_unit.sv
module cpgpr_unit
  import cpgpr_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RAM_AW = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cp_we,
  input  logic [ADDR_W-1:0] cp_wdata,
  output logic [ADDR_W-1:0] cp_q,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [7:0]        req_code,
  input  logic              req_write,
  input  logic [15:0]       req_wdata,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              is_byte,
  output logic              out_of_window,
  output logic              rsp_valid,
  output logic [15:0]       rsp_data
);
  logic ram_en;

  assign req_ready = 1'b1;

  cpgpr_ctx_reg #(.W(ADDR_W)) u_ctx (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cp_we),
    .wdata (cp_wdata),
    .q     (cp_q)
  );

  cpgpr_addr_calc #(.W(ADDR_W)) u_calc (
    .base     (cp_q),
    .kind     (opnd_kind_e'(req_kind)),
    .code     (req_code),
    .addr     (phys_addr),
    .byte_acc (is_byte),
    .oow      (out_of_window)
  );

  assign ram_en = req_valid && req_ready && !out_of_window;

  cpgpr_ram #(.AW(RAM_AW)) u_ram (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ram_en),
    .we       (req_write),
    .byte_acc (is_byte),
    .waddr    (phys_addr[RAM_AW:1]),
    .lane     (phys_addr[0]),
    .wdata    (req_wdata),
    .rvalid   (rsp_valid),
    .rdata    (rsp_data)
  );
endmodule

// File: rtl/cpgpr_unit_chk.sv
module cpgpr_unit_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned RAM_AW = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cp_we,
  input logic [ADDR_W-1:0] cp_wdata,
  input logic [ADDR_W-1:0] cp_q,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [7:0]        req_code,
  input logic              req_write,
  input logic [ADDR_W-1:0] phys_addr,
  input logic              is_byte,
  input logic              out_of_window,
  input logic              rsp_valid
);
  // R1
  base_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cp_we |=> (cp_q == {$past(cp_wdata[ADDR_W-1:1]), 1'b0}));

  // R2
  word_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd0) |->
      ((phys_addr - cp_q) == ADDR_W'({req_code[3:0], 1'b0}) && !is_byte));

  // R3
  byte_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd1) |->
      ((phys_addr - cp_q) == ADDR_W'(req_code[3:0]) && is_byte));

  // R4
  ptr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd2) |->
      ((phys_addr - cp_q) < ADDR_W'(8) && !phys_addr[0] && !is_byte));

  // R5
  sreg_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3 && req_code[7:4] == 4'hF) |->
      (!out_of_window && (phys_addr - cp_q) == ADDR_W'({req_code[3:0], 1'b0})));

  // R6
  sreg_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == 2'd3 && req_code[7:4] != 4'hF) |-> out_of_window);

  // R6
  oow_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && out_of_window) |=> !rsp_valid);

  // R7
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && !out_of_window) |=> rsp_valid);

  // R7
  wr_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_valid || req_write) |=> !rsp_valid);
endmodule

bind cpgpr_unit cpgpr_unit_chk #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_chk (.*);

// File: tb/cpgpr_unit_test.sv
module cpgpr_unit_test;
  localparam int PERIOD = 10;
  localparam int AW     = 16;
  localparam int RAW    = 5;
  localparam int NBYTES = 2 << RAW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cp_we = 1'b0;
  logic [AW-1:0] cp_wdata = '0;
  logic [AW-1:0] cp_q;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_kind = 2'd0;
  logic [7:0]    req_code = 8'h00;
  logic          req_write = 1'b0;
  logic [15:0]   req_wdata = '0;
  logic [AW-1:0] phys_addr;
  logic          is_byte;
  logic          out_of_window;
  logic          rsp_valid;
  logic [15:0]   rsp_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [7:0]    ref_mem [NBYTES];
  logic [AW-1:0] cur_cp = '0;

  always #(PERIOD/2) clk = ~clk;

  cpgpr_unit #(.ADDR_W(AW), .RAM_AW(RAW)) uut (.*);

  task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h expected=%h", rq, got, exp);
    end
  endtask

  // returns {oow, byte, addr}
  function automatic logic [AW+1:0] model_addr(input logic [1:0] k, input logic [7:0] c,
                                               input logic [AW-1:0] b);
    logic [AW-1:0] a;
    case (k)
      2'd0: return {2'b00, AW'(b + AW'({c[3:0], 1'b0}))};
      2'd1: return {2'b01, AW'(b + AW'(c[3:0]))};
      2'd2: return {2'b00, AW'(b + AW'({c[1:0], 1'b0}))};
      default: begin
        a = b + AW'({c[3:0], 1'b0});
        if (c[7:4] == 4'hF) return {2'b00, a};
        return {2'b10, b};
      end
    endcase
  endfunction

  task automatic set_cp(input logic [AW-1:0] v);
    cp_we = 1'b1; cp_wdata = v;
    @(posedge clk); @(negedge clk);
    cp_we = 1'b0;
    cur_cp = {v[AW-1:1], 1'b0};
    chk("R1", 32'(cp_q), 32'(cur_cp));
  endtask

  // one request starting at a negedge; returns at the following negedge
  task automatic access(input string rq, input logic [1:0] k, input logic [7:0] c,
                        input logic wr, input logic [15:0] wd);
    logic [AW+1:0] m;
    logic [5:0] ix;
    logic [15:0] exp_rd;
    m = model_addr(k, c, cur_cp);
    req_valid = 1'b1; req_kind = k; req_code = c; req_write = wr; req_wdata = wd;
    #1;
    chk(rq, 32'({out_of_window, is_byte}), 32'(m[AW+1:AW]));
    if (!m[AW+1]) chk(rq, 32'(phys_addr), 32'(m[AW-1:0]));
    ix = m[5:0];
    exp_rd = m[AW] ? {8'h00, ref_mem[ix]} : {ref_mem[{ix[5:1], 1'b1}], ref_mem[{ix[5:1], 1'b0}]};
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    if (!m[AW+1] && wr) begin
      if (m[AW]) ref_mem[ix] = wd[7:0];
      else begin
        ref_mem[{ix[5:1], 1'b0}] = wd[7:0];
        ref_mem[{ix[5:1], 1'b1}] = wd[15:8];
      end
    end
    #1;
    if (!m[AW+1] && !wr) begin
      chk({rq, "/R7"}, 32'(rsp_valid), 32'd1);
      chk(rq, 32'(rsp_data), 32'(exp_rd));
    end else begin
      chk({rq, "/no-rsp"}, 32'(rsp_valid), 32'd0);
    end
    @(negedge clk);
  endtask

  task automatic sweep_addr();
    logic [AW+1:0] m;
    for (int k = 0; k < 4; k++) begin
      for (int c = 0; c < 256; c++) begin
        req_kind = 2'(k); req_code = 8'(c);
        #1;
        m = model_addr(2'(k), 8'(c), cur_cp);
        case (k)
          0: begin chk("R2", 32'(is_byte), 32'd0); chk("R2", 32'(phys_addr), 32'(m[AW-1:0])); end
          1: begin chk("R3", 32'(is_byte), 32'd1); chk("R3", 32'(phys_addr), 32'(m[AW-1:0])); end
          2: begin chk("R4", 32'(is_byte), 32'd0); chk("R4", 32'(phys_addr), 32'(m[AW-1:0])); end
          default: begin
            chk(m[AW+1] ? "R6" : "R5", 32'(out_of_window), 32'(m[AW+1]));
            if (!m[AW+1]) chk("R5", 32'(phys_addr), 32'(m[AW-1:0]));
          end
        endcase
      end
    end
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NBYTES; i++) ref_mem[i] = 8'h00;
    #3;
    chk("R11", 32'(req_ready), 32'd1);
    chk("R1", 32'(cp_q), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 32'(rsp_valid), 32'd0);

    // address sweeps over several bases, including the wrap region (R10)
    set_cp(16'h0000); sweep_addr();
    set_cp(16'h0021); sweep_addr();
    set_cp(16'h7FFF); sweep_addr();
    set_cp(16'hFFF3); sweep_addr();
    chk("R10", 32'(model_addr(2'd0, 8'h0F, cur_cp)), 32'h0_0010);

    // fill a bank, read every word back (R7)
    set_cp(16'h0010);
    for (int i = 0; i < 16; i++) access("R2", 2'd0, 8'(i), 1'b1, 16'hA500 ^ 16'(i * 16'h0111));
    for (int i = 0; i < 16; i++) access("R7", 2'd0, 8'(i), 1'b0, 16'h0);
    // byte lanes (R8)
    for (int i = 0; i < 16; i++) access("R3", 2'd1, 8'(i), 1'b0, 16'h0);
    access("R8", 2'd1, 8'h05, 1'b1, 16'hFF3C);
    access("R8", 2'd1, 8'h0A, 1'b1, 16'h00C3);
    access("R8", 2'd0, 8'h02, 1'b0, 16'h0);
    access("R8", 2'd0, 8'h05, 1'b0, 16'h0);
    access("R8", 2'd1, 8'h05, 1'b0, 16'h0);
    // pointer kind ignores upper code bits (R4)
    access("R4", 2'd2, 8'hFE, 1'b0, 16'h0);
    access("R4", 2'd2, 8'h01, 1'b1, 16'h5A5A);
    access("R4", 2'd0, 8'h01, 1'b0, 16'h0);
    // eight-bit codes (R5, R6)
    access("R5", 2'd3, 8'hF3, 1'b1, 16'h1357);
    access("R5", 2'd0, 8'h03, 1'b0, 16'h0);
    access("R6", 2'd3, 8'h45, 1'b1, 16'hDEAD);
    access("R6", 2'd3, 8'hE7, 1'b0, 16'h0);
    for (int i = 0; i < 16; i++) access("R6", 2'd0, 8'(i), 1'b0, 16'h0);

    // base change timing (R9)
    cp_we = 1'b1; cp_wdata = 16'h0031; req_kind = 2'd0; req_code = 8'h02;
    #1;
    chk("R9", 32'(phys_addr), 32'h0014);
    @(posedge clk); @(negedge clk);
    cp_we = 1'b0; cur_cp = 16'h0030;
    #1;
    chk("R9", 32'(phys_addr), 32'h0034);
    @(negedge clk);
    access("R9", 2'd0, 8'h00, 1'b0, 16'h0);

    // wrap to address 0 (R10)
    set_cp(16'hFFFE);
    access("R10", 2'd0, 8'h01, 1'b1, 16'hBEEF);
    set_cp(16'h0000);
    access("R10", 2'd0, 8'h00, 1'b0, 16'h0);
    chk("R11", 32'(req_ready), 32'd1);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule